// File: doc/BRIEF.md
# Delay Address Update Sequencer

This block sits between a host and a programmable delay line whose address inputs are not latched. The host asks for a new delay address, or for a clean disable, through a valid/ready handshake. The sequencer times each change so that the line never produces a spurious edge. While it is idle, it passes the host's signal to the line input one clock later.

An address change runs in three steps. First the sequencer waits until the last transition it passed to the line has come out of the line. This takes the fixed inherent latency plus the current address, counted in cycles. Next it waits the positive part of (new address minus old address). Last it drives the new address and holds the line input low for a setup period before it returns to idle. A disable request holds the line's disable output high, with the line input low, for a time set by the current address. It then releases the disable and waits the setup period again, so the enable has settled before any edge reaches the line. All times are in clock cycles, and one delay step is one cycle.

Top module: `dly_addr_seq`

## Requirements
- R1: After reset, req_ready is 1, line_in is 0, line_dis is 0 and line_addr is 0.
- R2: While idle, line_in equals host_in as sampled one clock earlier.
- R3: A request (req_dis = 0) whose address equals line_addr is taken without req_ready going low, and line_addr is unchanged.
- R4: With no transition on line_in for a long time, an address increase keeps req_ready low for 1 + (new − old) + SETUP_CYC cycles.
- R5: With no transition on line_in for a long time, an address decrease keeps req_ready low for 1 + SETUP_CYC cycles. A decrease adds no difference wait.
- R6: line_addr changes only once LATENCY + old address cycles have passed since the last transition on line_in. The forced fall of line_in when a request is taken counts as such a transition.
- R7: line_in is 0 in every cycle in which req_ready is low.
- R8: For an address change, the new value is on line_addr for exactly SETUP_CYC cycles before req_ready returns high.
- R9: A request with req_dis = 1 drives line_dis high for max(A, 1) cycles, where A is the current address, and keeps line_addr unchanged. It then keeps line_dis low for SETUP_CYC cycles before req_ready returns, so req_ready stays low for max(A, 1) + SETUP_CYC cycles.
- R10: req_ready is high only when the block is idle. A request is taken when req_valid and req_ready are both high, and line_addr stays stable across consecutive idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_dis | input | 1 | 1 = disable sequence, 0 = address change |
| req_addr | input | ADDR_W | Requested delay address |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| host_in | input | 1 | Host signal to be delayed |
| line_in | output | 1 | Gated signal to the delay line input |
| line_addr | output | ADDR_W | Address driven onto the delay line |
| line_dis | output | 1 | Delay line disable (high = disabled) |

## Verification
The bench builds the block with ADDR_W = 4, LATENCY = 3 and SETUP_CYC = 2. With these values the whole address range can be reached in a short run. That range includes the largest increase (0 to 15), a disable from address 15 and a disable from address 0, where the one-cycle minimum applies. A two-cycle setup makes an off-by-one in the apply phase visible. The small latency lets the bench place a request two cycles after a real transition on line_in and observe a partial drain wait.

// File: rtl/dly_seq_pkg.sv
package dly_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_APPLY  = 3'd3,
        ST_DISCLR = 3'd4
    } seq_state_e;

    // Cycles to wait after drain before a larger address may be driven.
    function automatic int unsigned rise_wait(int unsigned nw, int unsigned od);
        return (nw > od) ? (nw - od) : 0;
    endfunction

    // Cycles the line is held disabled; never less than one.
    function automatic int unsigned clear_wait(int unsigned a);
        return (a == 0) ? 1 : a;
    endfunction

endpackage

// File: rtl/dly_seq_edge_age.sv
module dly_seq_edge_age #(
    parameter int AGE_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_i,
    output logic [AGE_W-1:0] age_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic             sig_q;
    logic [AGE_W-1:0] age_q;

    // Zero in the cycle the observed signal shows a new level.
    assign age_o = (sig_i != sig_q) ? '0 : age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q <= 1'b0;
            age_q <= AGE_MAX;
        end else begin
            sig_q <= sig_i;
            age_q <= (age_o == AGE_MAX) ? AGE_MAX : age_o + 1'b1;
        end
    end
endmodule

// File: rtl/dly_seq_gate.sv
module dly_seq_gate (
    input  logic clk,
    input  logic rst,
    input  logic pass_i,
    input  logic host_i,
    output logic line_o
);
    always_ff @(posedge clk) begin
        if (rst) line_o <= 1'b0;
        else     line_o <= pass_i & host_i;
    end
endmodule

// File: rtl/dly_seq_ctrl.sv
module dly_seq_ctrl
    import dly_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LATENCY   = 4,
    parameter int SETUP_CYC = 1,
    parameter int AGE_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_dis,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AGE_W-1:0]  edge_age,
    output logic              req_ready,
    output logic              pass_next,
    output logic [ADDR_W-1:0] line_addr,
    output logic              line_dis
);
    localparam int SET_W = $clog2(SETUP_CYC + 1);
    localparam int CNT_W = (ADDR_W > SET_W) ? ADDR_W : SET_W;
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);

    seq_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ADDR_W-1:0] cur_q, cur_n;
    logic [ADDR_W-1:0] tgt_q, tgt_n;
    logic              dis_q;
    logic [AGE_W-1:0]  drain_need;
    logic [CNT_W-1:0]  diff_w;
    logic [CNT_W-1:0]  clr_w;

    assign drain_need = AGE_W'(LATENCY) + AGE_W'(cur_q);
    assign diff_w     = CNT_W'(rise_wait(32'(tgt_q), 32'(cur_q)));
    assign clr_w      = CNT_W'(clear_wait(32'(cur_q)));

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        cur_n   = cur_q;
        tgt_n   = tgt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_dis) begin
                        state_n = ST_DISCLR;
                        cnt_n   = clr_w - 1'b1;
                    end else if (req_addr != cur_q) begin
                        state_n = ST_DRAIN;
                        tgt_n   = req_addr;
                    end
                end
            end
            ST_DRAIN: begin
                if (edge_age >= drain_need) begin
                    if (diff_w == '0) begin
                        state_n = ST_APPLY;
                        cur_n   = tgt_q;
                        cnt_n   = SETUP_LAST;
                    end else begin
                        state_n = ST_SETTLE;
                        cnt_n   = diff_w - 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_n = ST_APPLY;
                    cur_n   = tgt_q;
                    cnt_n   = SETUP_LAST;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_APPLY: begin
                if (cnt_q == '0) state_n = ST_IDLE;
                else             cnt_n   = cnt_q - 1'b1;
            end
            ST_DISCLR: begin
                if (cnt_q == '0) begin
                    state_n = ST_APPLY;
                    cnt_n   = SETUP_LAST;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            tgt_q   <= '0;
            dis_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            cur_q   <= cur_n;
            tgt_q   <= tgt_n;
            dis_q   <= (state_n == ST_DISCLR);
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign pass_next = (state_n == ST_IDLE);
    assign line_addr = cur_q;
    assign line_dis  = dis_q;

    // R6: the driven address moves only after in-flight edges have left the line
    a_r6_drain_before_change: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> (edge_age >= AGE_W'(LATENCY) + AGE_W'($past(cur_q))));
endmodule

// File: rtl/dly_addr_seq.sv
module dly_addr_seq #(
    parameter int ADDR_W    = 8,
    parameter int LATENCY   = 4,
    parameter int SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_dis,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              host_in,
    output logic              line_in,
    output logic [ADDR_W-1:0] line_addr,
    output logic              line_dis
);
    localparam int AGE_W = $clog2(LATENCY + (2 ** ADDR_W) + 1);

    logic [AGE_W-1:0] edge_age;
    logic             pass_next;

    dly_seq_edge_age #(.AGE_W(AGE_W)) u_age (
        .clk   (clk),
        .rst   (rst),
        .sig_i (line_in),
        .age_o (edge_age)
    );

    dly_seq_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .pass_i (pass_next),
        .host_i (host_in),
        .line_o (line_in)
    );

    dly_seq_ctrl #(
        .ADDR_W    (ADDR_W),
        .LATENCY   (LATENCY),
        .SETUP_CYC (SETUP_CYC),
        .AGE_W     (AGE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_dis   (req_dis),
        .req_addr  (req_addr),
        .edge_age  (edge_age),
        .req_ready (req_ready),
        .pass_next (pass_next),
        .line_addr (line_addr),
        .line_dis  (line_dis)
    );

    // R7: the line input is held low throughout any sequence
    a_r7_gate_low: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !line_in);

    // R9: address is frozen while the line is disabled
    a_r9_addr_hold_dis: assert property (@(posedge clk) disable iff (rst)
        line_dis |-> $stable(line_addr));

    // R9: enable has been released before the host regains the line
    a_r9_enable_settled: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> !$past(line_dis));

    // R10: address never moves between idle cycles
    a_r10_idle_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (req_ready && $past(req_ready)) |-> $stable(line_addr));
endmodule

// File: tb/dly_addr_seq_tb.sv
`timescale 1ns/1ps
module dly_addr_seq_tb_top;
    localparam int AW  = 4;
    localparam int LAT = 3;
    localparam int SU  = 2;
    localparam int NV  = 9;

    // {req_dis, host level, address}
    localparam logic [5:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'd5},
        {1'b0, 1'b1, 4'd9},
        {1'b0, 1'b0, 4'd2},
        {1'b0, 1'b1, 4'd2},
        {1'b0, 1'b1, 4'd0},
        {1'b1, 1'b1, 4'd0},
        {1'b0, 1'b0, 4'd15},
        {1'b1, 1'b1, 4'd0},
        {1'b0, 1'b0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_dis = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          host_in = 1'b0;
    logic          line_in;
    logic [AW-1:0] line_addr;
    logic          line_dis;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dly_addr_seq #(.ADDR_W(AW), .LATENCY(LAT), .SETUP_CYC(SU)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dis(req_dis),
        .req_addr(req_addr), .req_ready(req_ready), .host_in(host_in),
        .line_in(line_in), .line_addr(line_addr), .line_dis(line_dis)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_busy(bit dis, bit host, int a_old, int a_new);
        int drain;
        if (dis) return ((a_old == 0) ? 1 : a_old) + SU;
        if (a_new == a_old) return 0;
        drain = host ? (LAT + a_old + 1) : 1;
        return drain + ((a_new > a_old) ? (a_new - a_old) : 0) + SU;
    endfunction

    // Called at a falling edge; returns cycle counts of the sequence.
    task automatic do_req(input bit dis, input int addr, output int busy,
                          output int dcyc, output int hi_in, output int newc);
        req_valid = 1'b1;
        req_dis   = dis;
        req_addr  = AW'(addr);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; dcyc = 0; hi_in = 0; newc = 0;
        while (!req_ready && busy < 1000) begin
            busy++;
            if (line_dis) dcyc++;
            if (line_in) hi_in++;
            if (int'(line_addr) == addr) newc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cur;
        int busy, dcyc, hi_in, newc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(int'(req_ready), 1, "R1 ready");
        check(int'(line_in),   0, "R1 line_in");
        check(int'(line_dis),  0, "R1 line_dis");
        check(int'(line_addr), 0, "R1 line_addr");

        // R2 pass-through one cycle later
        host_in = 1'b1;
        @(negedge clk);
        check(int'(line_in), 1, "R2 rise");
        host_in = 1'b0;
        @(negedge clk);
        check(int'(line_in), 0, "R2 fall");

        cur = 0;
        for (int i = 0; i < NV; i++) begin
            bit dis, host;
            int a;
            int exp_b;
            dis  = VEC[i][5];
            host = VEC[i][4];
            a    = int'(VEC[i][3:0]);
            host_in = host;
            repeat (40) @(negedge clk);
            exp_b = model_busy(dis, host, cur, a);
            do_req(dis, a, busy, dcyc, hi_in, newc);
            if (dis)            check(busy, exp_b, "R9 busy");
            else if (a == cur)  check(busy, exp_b, "R3 busy");
            else if (host)      check(busy, exp_b, "R6 busy");
            else if (a > cur)   check(busy, exp_b, "R4 busy");
            else                check(busy, exp_b, "R5 busy");
            check(dcyc, dis ? ((cur == 0) ? 1 : cur) : 0, "R9 disable cycles");
            check(hi_in, 0, "R7 gated input");
            if (!dis && a != cur) check(newc, SU, "R8 setup cycles");
            if (!dis) cur = a;
            check(int'(line_addr), cur, "R10 final address");
            check(int'(req_ready), 1, "R10 ready back");
        end

        // R6 partial drain: request two cycles after a real line_in fall
        host_in = 1'b1;
        repeat (40) @(negedge clk);
        host_in = 1'b0;
        @(negedge clk);
        do_req(1'b0, 3, busy, dcyc, hi_in, newc);
        check(busy, LAT + 3 + SU, "R6 recent edge");
        check(newc, SU, "R8 after recent edge");
        check(int'(line_addr), 3, "R6 address");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule